// File: doc/BRIEF.md
# Synchronous Serial Frame Receiver

This block recovers characters from a serial data line that comes with its own bit clock. The bit clock and the data line are both brought into the system clock domain through a two-flop synchronizer. The receiver samples the data line on one edge of the bit clock, and a polarity input selects which edge. A frame starts with a low start bit. The data bits follow, least significant first. An optional parity bit comes next, and then one or two stop bits.

The format is set at run time. The word length is 5 to 9 bits, parity can be none, even or odd, and one or two stop bits can be selected. The receiver takes the format when it sees the start bit. At the end of each frame it presents the assembled word for one cycle with a valid strobe. The same cycle carries a frame-error flag and a parity-error flag. The word and both flags stay on the outputs until the next frame completes.

Top module: `sync_frame_rx`

## Requirements
- R1: With `cfg_pol`=0 the data line is sampled on rising `sck_in` edges. With `cfg_pol`=1 it is sampled on falling edges. The line changes on the opposite edge.
- R2: When no frame is in progress, a high sample is idle and produces no output. The first low sample starts a frame.
- R3: Data bits are received least significant bit first into `rx_word`. The count equals the value of `cfg_nbits`, from 5 to 9.
- R4: Bits of `rx_word` at or above the configured count read as zero.
- R5: `cfg_par` uses this encoding: 0x means no parity bit, 10 means even parity and 11 means odd parity. When parity is enabled, the parity bit is sampled right after the last data bit. `rx_par_err` is set when the parity bit does not equal the XOR of the data bits, inverted for odd parity. With no parity, the flag is always 0.
- R6: `cfg_two_stop`=1 checks two stop bits and 0 checks one. `rx_frame_err` is set when any checked stop bit is sampled low.
- R7: A start bit may be sampled immediately after the last stop bit. Back-to-back frames are each received correctly.
- R8: `rx_valid` is high for exactly one cycle after the last stop bit is sampled, with the word and both flags valid in that cycle. Between strobes the word and flags hold their values.
- R9: While `rst` is high, all outputs go to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | External bit clock |
| sdata_in | input | 1 | Serial data line |
| cfg_pol | input | 1 | Sampling edge select (0 rising, 1 falling) |
| cfg_nbits | input | 4 | Number of data bits, 5 to 9 |
| cfg_par | input | 2 | Parity mode (0x none, 10 even, 11 odd) |
| cfg_two_stop | input | 1 | Two stop bits when 1 |
| rx_word | output | 9 | Received data word |
| rx_valid | output | 1 | One-cycle frame-complete strobe |
| rx_frame_err | output | 1 | A checked stop bit was low |
| rx_par_err | output | 1 | Parity bit mismatch |

## Verification
The bench changes the data line on the edge opposite the sampling edge, under both polarities. A receiver that uses the wrong edge then picks up the previous bit and returns shifted words. The word-length extremes of 5 and 9 bits are sent with all-ones data. A design that leaves the upper bits dirty, or drops or adds a bit, shows up as a wrong word.

Parity is sent both correct and corrupted in each mode, and stop bits are forced low one at a time in both stop-bit settings. These frames expose a flipped parity sense, an unchecked second stop bit, and a stale error flag. Frames are also sent back to back, and idle-high edges are sent between frames. A receiver that needs an idle gap loses a character, and one that treats a high sample as a start bit produces an unexpected strobe.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_DATA,
    RX_PAR,
    RX_STOP1,
    RX_STOP2
  } rx_state_t;
endpackage

// File: rtl/sfr_edge_sync.sv
module sfr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_raw,
  input  logic sd_raw,
  input  logic pol,
  output logic edge_o,
  output logic bit_o
);
  logic [STAGES-1:0] sck_q;
  logic [STAGES-1:0] sd_q;
  logic              sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q[0] <= 1'b0;
      sd_q[0]  <= 1'b1;
    end else begin
      sck_q[0] <= sck_raw;
      sd_q[0]  <= sd_raw;
    end
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        sck_q[i] <= 1'b0;
        sd_q[i]  <= 1'b1;
      end else begin
        sck_q[i] <= sck_q[i-1];
        sd_q[i]  <= sd_q[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck_q[STAGES-1];
  end

  // data travels through the same number of stages, so it stays aligned with the clock
  always_comb begin
    if (pol) edge_o = sck_prev & ~sck_q[STAGES-1];
    else     edge_o = ~sck_prev & sck_q[STAGES-1];
    bit_o = sd_q[STAGES-1];
  end
endmodule

// File: rtl/sfr_deser.sv
module sfr_deser
  import sfr_pkg::*;
#(
  parameter int MIN_BITS = 5,
  parameter int MAX_BITS = 9,
  localparam int CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_edge,
  input  logic                smp_bit,
  input  logic [CW-1:0]       cfg_nbits,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  output logic [MAX_BITS-1:0] word_o,
  output logic                valid_o,
  output logic                ferr_o,
  output logic                perr_o,
  output logic [CW-1:0]       frm_nbits,
  output logic                frm_par_en
);
  rx_state_t           st;
  logic [CW-1:0]       cnt;
  logic [MAX_BITS-1:0] shreg;
  logic                par_odd;
  logic                two_stop;
  logic                par_rx;
  logic                ferr_acc;
  logic [CW-1:0]       n_clamped;
  logic                par_bad;

  always_comb begin
    if (cfg_nbits < CW'(MIN_BITS))      n_clamped = CW'(MIN_BITS);
    else if (cfg_nbits > CW'(MAX_BITS)) n_clamped = CW'(MAX_BITS);
    else                                n_clamped = cfg_nbits;
    par_bad = frm_par_en & (par_rx ^ (^shreg) ^ par_odd);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= RX_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      par_odd    <= 1'b0;
      two_stop   <= 1'b0;
      par_rx     <= 1'b0;
      ferr_acc   <= 1'b0;
      frm_nbits  <= CW'(MIN_BITS);
      frm_par_en <= 1'b0;
      word_o     <= '0;
      valid_o    <= 1'b0;
      ferr_o     <= 1'b0;
      perr_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (smp_edge) begin
        unique case (st)
          RX_IDLE: if (!smp_bit) begin
            shreg      <= '0;
            cnt        <= '0;
            ferr_acc   <= 1'b0;
            par_rx     <= 1'b0;
            frm_nbits  <= n_clamped;
            frm_par_en <= cfg_par[1];
            par_odd    <= cfg_par[0];
            two_stop   <= cfg_two_stop;
            st         <= RX_DATA;
          end
          RX_DATA: begin
            shreg[cnt] <= smp_bit;
            cnt        <= cnt + 1'b1;
            if (cnt == frm_nbits - 1'b1) st <= frm_par_en ? RX_PAR : RX_STOP1;
          end
          RX_PAR: begin
            par_rx <= smp_bit;
            st     <= RX_STOP1;
          end
          RX_STOP1: begin
            if (two_stop) begin
              ferr_acc <= ~smp_bit;
              st       <= RX_STOP2;
            end else begin
              word_o  <= shreg;
              valid_o <= 1'b1;
              ferr_o  <= ~smp_bit;
              perr_o  <= par_bad;
              st      <= RX_IDLE;
            end
          end
          RX_STOP2: begin
            word_o  <= shreg;
            valid_o <= 1'b1;
            ferr_o  <= ferr_acc | ~smp_bit;
            perr_o  <= par_bad;
            st      <= RX_IDLE;
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sync_frame_rx.sv
module sync_frame_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_BITS    = 5,
  parameter int MAX_BITS    = 9,
  localparam int CW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sck_in,
  input  logic                sdata_in,
  input  logic                cfg_pol,
  input  logic [CW-1:0]       cfg_nbits,
  input  logic [1:0]          cfg_par,
  input  logic                cfg_two_stop,
  output logic [MAX_BITS-1:0] rx_word,
  output logic                rx_valid,
  output logic                rx_frame_err,
  output logic                rx_par_err
);
  logic          smp_edge;
  logic          smp_bit;
  logic [CW-1:0] frm_nbits;
  logic          frm_par_en;

  sfr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .sck_raw (sck_in),
    .sd_raw  (sdata_in),
    .pol     (cfg_pol),
    .edge_o  (smp_edge),
    .bit_o   (smp_bit)
  );

  sfr_deser #(.MIN_BITS(MIN_BITS), .MAX_BITS(MAX_BITS)) u_deser (
    .clk          (clk),
    .rst          (rst),
    .smp_edge     (smp_edge),
    .smp_bit      (smp_bit),
    .cfg_nbits    (cfg_nbits),
    .cfg_par      (cfg_par),
    .cfg_two_stop (cfg_two_stop),
    .word_o       (rx_word),
    .valid_o      (rx_valid),
    .ferr_o       (rx_frame_err),
    .perr_o       (rx_par_err),
    .frm_nbits    (frm_nbits),
    .frm_par_en   (frm_par_en)
  );
endmodule

// File: rtl/sync_frame_rx_chk.sv
module sync_frame_rx_chk #(
  parameter int MAX_BITS = 9,
  parameter int CW = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_edge,
  input logic [CW-1:0]       frm_nbits,
  input logic                frm_par_en,
  input logic [MAX_BITS-1:0] rx_word,
  input logic                rx_valid,
  input logic                rx_frame_err,
  input logic                rx_par_err
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  // R8
  valid_after_edge_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(smp_edge));
  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |-> ($stable(rx_word) && $stable(rx_frame_err) && $stable(rx_par_err)));
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> ((rx_word >> frm_nbits) == '0));
  // R5
  no_par_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !frm_par_en) |-> !rx_par_err);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rx_valid && rx_word == '0 && !rx_frame_err && !rx_par_err));
endmodule

bind sync_frame_rx sync_frame_rx_chk #(.MAX_BITS(MAX_BITS), .CW(CW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .smp_edge     (smp_edge),
  .frm_nbits    (frm_nbits),
  .frm_par_en   (frm_par_en),
  .rx_word      (rx_word),
  .rx_valid     (rx_valid),
  .rx_frame_err (rx_frame_err),
  .rx_par_err   (rx_par_err)
);

// File: tb/sync_frame_rx_bench.sv
module sync_frame_rx_bench;
  localparam int HALF = 4;

  typedef struct packed {
    logic [8:0] word;
    logic       ferr;
    logic       perr;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck_in = 1'b0;
  logic       sdata_in = 1'b1;
  logic       cfg_pol = 1'b0;
  logic [3:0] cfg_nbits = 4'd8;
  logic [1:0] cfg_par = 2'b00;
  logic       cfg_two_stop = 1'b0;
  logic [8:0] rx_word;
  logic       rx_valid;
  logic       rx_frame_err;
  logic       rx_par_err;

  exp_t       sb_q[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic       pend = 1'b0;
  logic [8:0] last_word = '0;

  always #4 clk = ~clk;

  sync_frame_rx u_sync_frame_rx (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sdata_in(sdata_in),
    .cfg_pol(cfg_pol), .cfg_nbits(cfg_nbits), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .rx_word(rx_word), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic send_bit(input logic b);
    sck_in   = cfg_pol;
    sdata_in = b;
    repeat (HALF) @(negedge clk);
    sck_in = ~cfg_pol;
    repeat (HALF) @(negedge clk);
  endtask

  // scoreboard driver: pushes the expected result, then drives the frame
  task automatic send_frame(input logic [8:0] data, input logic pol, input logic [3:0] n,
                            input logic [1:0] par, input logic two, input logic bad_par,
                            input logic bad_s1, input logic bad_s2);
    logic [8:0] m;
    logic       p;
    exp_t       e;
    cfg_pol = pol; cfg_nbits = n; cfg_par = par; cfg_two_stop = two;
    m = data & ((9'd1 << n) - 9'd1);
    p = (^m) ^ par[0];
    e.word = m;
    e.ferr = bad_s1 | (two & bad_s2);
    e.perr = par[1] & bad_par;
    sb_q.push_back(e);
    send_bit(1'b0);
    for (int i = 0; i < int'(n); i++) send_bit(data[i]);
    if (par[1]) send_bit(p ^ bad_par);
    send_bit(~bad_s1);
    if (two) send_bit(~bad_s2);
  endtask

  // monitor
  always @(negedge clk) begin
    if (pend) begin
      chk("R8 strobe one cycle", {8'd0, rx_valid}, 9'd0);
      pend = 1'b0;
    end
    if (!rst && rx_valid) begin
      if (sb_q.size() == 0) begin
        chk("R2 unexpected frame", 9'd1, 9'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R1/R3/R4/R7 word", rx_word, e.word);
        chk("R6 frame error", {8'd0, rx_frame_err}, {8'd0, e.ferr});
        chk("R5 parity error", {8'd0, rx_par_err}, {8'd0, e.perr});
        last_word = e.word;
      end
      pend = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9 word", rx_word, 9'd0);
    chk("R9 valid", {8'd0, rx_valid}, 9'd0);
    chk("R9 ferr", {8'd0, rx_frame_err}, 9'd0);
    chk("R9 perr", {8'd0, rx_par_err}, 9'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 rising edge, R3 eight bits
    send_frame(9'h0A5, 1'b0, 4'd8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R2 idle high samples produce nothing
    repeat (3) send_bit(1'b1);
    // R1 falling edge
    send_frame(9'h03C, 1'b1, 4'd8, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    send_bit(1'b1);
    // R4 five bits from all-ones, R3 nine bits
    send_frame(9'h1FF, 1'b0, 4'd5, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h1A5, 1'b0, 4'd9, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h1FF, 1'b1, 4'd9, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    // R5 even and odd parity, good and corrupted
    send_frame(9'h05A, 1'b0, 4'd7, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h05B, 1'b0, 4'd7, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame(9'h0C3, 1'b1, 4'd8, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h0C7, 1'b1, 4'd8, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
    send_frame(9'h013, 1'b0, 4'd6, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    // R6 stop bits
    send_frame(9'h066, 1'b0, 4'd8, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(9'h066, 1'b0, 4'd8, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
    send_bit(1'b1);
    send_frame(9'h099, 1'b0, 4'd8, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
    send_bit(1'b1);
    send_frame(9'h011, 1'b1, 4'd8, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0);
    send_bit(1'b1);
    // R7 back-to-back frames with differing formats
    send_frame(9'h081, 1'b1, 4'd8, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0);
    send_frame(9'h1FE, 1'b1, 4'd9, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
    send_frame(9'h015, 1'b1, 4'd5, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
    // R8 outputs hold between strobes
    repeat (3) send_bit(1'b1);
    chk("R8 word held", rx_word, last_word);
    chk("R2 queue drained", 9'(sb_q.size()), 9'd0);
    finish_run();
  end
endmodule